// File: doc/BRIEF.md
# Watchdog Timer with Two-Write Refresh and Selectable Prescaler

This block supervises a small processor. Once it is switched on, it advances a counter at a rate derived from the system clock. If software does not service the counter before it wraps past its all-ones value, the block issues a reset request to the processor and records the event in a status flag.

Servicing takes two register writes. The first write arms the refresh and the second write starts it. The start write has an effect only when it is the very next register write after the arm write, so a stray write from runaway code is unlikely to keep the timer alive by accident. A refresh loads the upper part of the counter from a software-set reload field and clears the lower part.

A prescale select in the same reload register picks one of two counting rates, divide-by-24 or divide-by-384, which gives a coarse and a fine range of timeout lengths.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset the reset request is 0, the status flag is 0, the watchdog is disabled, and the counter, the reload field and the prescale select are all 0.
- R2: While the enable bit is 0, the counter and the prescaler hold their values and no reset request is issued.
- R3: With prescale select 0, the counter advances once every 24 system clocks. A full count from 0 raises the reset request exactly 24 × 2^(LO_W+HI_W) clocks after the edge that enables the watchdog.
- R4: With prescale select 1 (reload-register bit HI_W, bit 7 at the default widths), the counter advances once every 384 system clocks.
- R5: An arm write followed directly by a start write is a refresh. The refresh loads the upper HI_W counter bits from reload-register bits HI_W-1:0 and clears the lower LO_W bits. The timeout is then (2^HI_W − reload) × 2^LO_W × prescale clocks, and no reset request occurs on the edge of the refresh.
- R6: Any enable, reload or status write between the arm write and the start write cancels the armed state. A start write that has no arm write directly before it does not refresh.
- R7: The reset request lasts one clock. On that same edge the counter loads the reload value and, while still enabled, keeps counting, so the next request follows one full reload period later.
- R8: The status flag becomes 1 on the edge that raises the reset request. Writing 0 to the flag clears it. Writing 1 to the flag has no effect.
- R9: Writing enable = 1 while the watchdog is disabled restarts the prescaler from zero. The counter resumes from the value it held when the watchdog was disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable value written |
| arm_wr | input | 1 | Write that sets the refresh-arm bit |
| start_wr | input | 1 | Write that sets the start bit |
| rld_wr | input | 1 | Write strobe for the reload register |
| rld_wdata | input | HI_W+1 | Bit HI_W is the prescale select; bits HI_W-1:0 are the reload value |
| stat_wr | input | 1 | Write strobe for the status flag |
| stat_wdata | input | 1 | Status value written (only 0 has an effect) |
| rst_req | output | 1 | One-clock processor reset request |
| stat_flag | output | 1 | Sticky overflow status |

## Verification
A counter that is loaded wrongly on a refresh, or a prescaler phase that is wrong, stays hidden until the timeout. It then shows as a reset request on the wrong clock, which can be thousands of cycles after the fault. For this reason the bench compares the request and the flag with a behavioural model on every clock, and it also measures each timeout length against its closed-form value. A sequencing fault in the arm and start logic shows up as a timeout of full length where a shortened one was expected, or the reverse. A flag fault shows on the first overflow or on the first write to the flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Number of divider stages in the prescale chain
  localparam int unsigned STAGES = 3;

  // Register write strobes seen by the control block
  typedef struct packed {
    logic en;
    logic arm;
    logic start;
    logic rld;
    logic stat;
  } wdog_wr_t;
endpackage

// File: rtl/wdog_div_stage.sv
module wdog_div_stage #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic carry
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign carry = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= carry ? '0 : cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_A = 12,
  parameter int unsigned DIV_B = 2,
  parameter int unsigned DIV_C = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic sel,
  output logic tick
);
  import wdog_pkg::*;

  localparam int unsigned DIV_LIST [STAGES] = '{DIV_A, DIV_B, DIV_C};

  logic [STAGES-1:0] carry;
  logic [STAGES-1:0] adv;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign adv[g] = run;
    end else begin : g_next
      assign adv[g] = carry[g-1];
    end
    wdog_div_stage #(.DIV(DIV_LIST[g])) u_div (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .adv  (adv[g]),
      .carry(carry[g])
    );
  end

  // Short range stops after stage B, long range after stage C
  assign tick = sel ? carry[STAGES-1] : carry[STAGES-2];
endmodule

// File: rtl/wdog_arm_seq.sv
module wdog_arm_seq (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  input  logic start_set,
  input  logic other_wr,
  output logic refresh
);
  logic armed_q;

  assign refresh = armed_q && start_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (arm_set) begin
      armed_q <= 1'b1;
    end else if (start_set || other_wr) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            refresh,
  input  logic [HI_W-1:0] rel_hi,
  output logic            ovf
);
  localparam int unsigned CW = LO_W + HI_W;

  logic [CW-1:0] cnt_q;

  assign ovf = tick && !refresh && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (refresh || ovf) begin
      cnt_q <= {rel_hi, {LO_W{1'b0}}};
    end else if (tick) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned HI_W  = 7,
  parameter int unsigned DIV_A = 12,
  parameter int unsigned DIV_B = 2,
  parameter int unsigned DIV_C = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          arm_wr,
  input  logic          start_wr,
  input  logic          rld_wr,
  input  logic [HI_W:0] rld_wdata,
  input  logic          stat_wr,
  input  logic          stat_wdata,
  output logic          rst_req,
  output logic          stat_flag
);
  import wdog_pkg::*;

  wdog_wr_t        wr;
  logic            en_q;
  logic            sel_q;
  logic [HI_W-1:0] rel_q;
  logic            req_q;
  logic            stat_q;
  logic            en_rise;
  logic            tick;
  logic            refresh_hit;
  logic            ovf;

  assign wr = '{en: en_wr, arm: arm_wr, start: start_wr, rld: rld_wr, stat: stat_wr};
  assign en_rise = wr.en && en_wdata && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      rel_q <= '0;
    end else begin
      if (wr.en) en_q <= en_wdata;
      if (wr.rld) begin
        sel_q <= rld_wdata[HI_W];
        rel_q <= rld_wdata[HI_W-1:0];
      end
    end
  end

  wdog_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk (clk),
    .rst (rst),
    .clr (en_rise),
    .run (en_q),
    .sel (sel_q),
    .tick(tick)
  );

  wdog_arm_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .arm_set  (wr.arm),
    .start_set(wr.start),
    .other_wr (wr.en || wr.rld || wr.stat),
    .refresh  (refresh_hit)
  );

  wdog_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .refresh(refresh_hit),
    .rel_hi (rel_q),
    .ovf    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      req_q <= ovf;
      if (ovf) begin
        stat_q <= 1'b1;
      end else if (wr.stat && !stat_wdata) begin
        stat_q <= 1'b0;
      end
    end
  end

  assign rst_req   = req_q;
  assign stat_flag = stat_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst,
  input logic rst_req,
  input logic stat_flag,
  input logic stat_wr,
  input logic stat_wdata,
  input logic en_q,
  input logic refresh_hit
);
  // R1: outputs are clear right after a reset cycle
  p_clear_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rst_req && !stat_flag));

  // R2: a request needs the watchdog to have been enabled
  p_req_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(en_q));

  // R5: a refresh edge never produces a request
  p_refresh_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    refresh_hit |=> !rst_req);

  // R7: the request is a single-clock pulse
  p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R8: the flag is set together with the request
  p_flag_with_req_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> stat_flag);

  // R8: only a write of 0 clears the flag
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_flag && !(stat_wr && !stat_wdata)) |=> stat_flag);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rst_req    (rst_req),
  .stat_flag  (stat_flag),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .en_q       (en_q),
  .refresh_hit(refresh_hit)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 4;
  localparam int HI_W = 4;
  localparam int P0 = 24;
  localparam int P1 = 384;
  localparam int MAXC = (1 << (LO_W + HI_W)) - 1;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 0, en_wdata = 0, arm_wr = 0, start_wr = 0, rld_wr = 0;
  logic stat_wr = 0, stat_wdata = 0;
  logic [HI_W:0] rld_wdata = '0;
  logic rst_req, stat_flag;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.LO_W(LO_W), .HI_W(HI_W)) u_wdog_timer (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .arm_wr(arm_wr), .start_wr(start_wr), .rld_wr(rld_wr),
    .rld_wdata(rld_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .rst_req(rst_req), .stat_flag(stat_flag)
  );

  // Behavioural reference model
  int m_pre, m_cnt, m_rel;
  bit m_en, m_sel, m_armed, m_req, m_stat;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_rel = 0;
      m_en = 0; m_sel = 0; m_armed = 0; m_req = 0; m_stat = 0;
    end else begin
      bit tick, rq, refr;
      tick = 0; rq = 0;
      refr = m_armed && start_wr;
      if (m_en) begin
        m_pre++;
        if (m_pre == (m_sel ? P1 : P0)) begin m_pre = 0; tick = 1; end
      end
      if (refr) m_cnt = m_rel << LO_W;
      else if (tick) begin
        if (m_cnt == MAXC) begin m_cnt = m_rel << LO_W; rq = 1; end
        else m_cnt++;
      end
      m_req = rq;
      if (rq) m_stat = 1;
      else if (stat_wr && !stat_wdata) m_stat = 0;
      if (arm_wr) m_armed = 1;
      else if (start_wr || en_wr || rld_wr || stat_wr) m_armed = 0;
      if (en_wr) begin
        if (en_wdata && !m_en) m_pre = 0;
        m_en = en_wdata;
      end
      if (rld_wr) begin m_sel = rld_wdata[HI_W]; m_rel = int'(rld_wdata[HI_W-1:0]); end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model, and watchdog
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check({phase, " req vs model"}, int'(rst_req), int'(m_req));
      check({phase, " flag vs model"}, int'(stat_flag), int'(m_stat));
    end
    if (cycles > LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse_en(bit v);
    en_wr = 1; en_wdata = v; @(negedge clk); en_wr = 0; en_wdata = 0;
  endtask
  task automatic pulse_arm();
    arm_wr = 1; @(negedge clk); arm_wr = 0;
  endtask
  task automatic pulse_start();
    start_wr = 1; @(negedge clk); start_wr = 0;
  endtask
  task automatic pulse_rld(logic [HI_W:0] v);
    rld_wr = 1; rld_wdata = v; @(negedge clk); rld_wr = 0; rld_wdata = '0;
  endtask
  task automatic pulse_stat(bit v);
    stat_wr = 1; stat_wdata = v; @(negedge clk); stat_wr = 0; stat_wdata = 0;
  endtask

  // Counts negedges until the request is seen (clocks since the last write edge)
  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rst_req && n < 30000);
  endtask

  task automatic do_reset();
    rst = 1; repeat (2) @(negedge clk); rst = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 req after reset", int'(rst_req), 0);
    check("R1 flag after reset", int'(stat_flag), 0);

    // R2 disabled: nothing happens
    phase = "R2";
    n = 0;
    repeat (400) begin @(negedge clk); if (rst_req) n++; end
    check("R2 requests while disabled", n, 0);

    // R3 full count at divide-by-24
    phase = "R3";
    pulse_en(1);
    wait_req(n);
    check("R3 timeout clocks", n, P0 * (MAXC + 1));
    check("R8 flag set on overflow", int'(stat_flag), 1);
    @(negedge clk);
    check("R7 request one clock", int'(rst_req), 0);
    // R7 keeps counting from reload value 0
    phase = "R7";
    wait_req(n);
    check("R7 second period", n, P0 * (MAXC + 1) - 1);

    // R8 flag writes
    phase = "R8";
    pulse_stat(1);
    check("R8 write 1 keeps flag", int'(stat_flag), 1);
    pulse_stat(0);
    check("R8 write 0 clears flag", int'(stat_flag), 0);

    // R5 refresh with reload 12 while disabled, then enable
    phase = "R5";
    pulse_en(0);
    pulse_rld({1'b0, 4'd12});
    pulse_arm();
    pulse_start();
    pulse_en(1);
    wait_req(n);
    check("R5 shortened timeout", n, (16 - 12) * 16 * P0);

    // R6 cancelled arm gives full-length timeout
    phase = "R6";
    do_reset();
    pulse_rld({1'b0, 4'd12});
    pulse_arm();
    pulse_stat(0);
    pulse_start();
    pulse_en(1);
    wait_req(n);
    check("R6 intervening write cancels", n, P0 * (MAXC + 1));
    do_reset();
    pulse_rld({1'b0, 4'd12});
    pulse_start();
    pulse_en(1);
    wait_req(n);
    check("R6 lone start ignored", n, P0 * (MAXC + 1));

    // R4 long prescale with refresh to 12
    phase = "R4";
    do_reset();
    pulse_rld({1'b1, 4'd12});
    pulse_arm();
    pulse_start();
    pulse_en(1);
    wait_req(n);
    check("R4 divide-by-384 timeout", n, (16 - 12) * 16 * P1);

    // R9 disable holds, re-enable restarts prescaler
    phase = "R9";
    do_reset();
    pulse_en(1);
    repeat (P0 * 100 + 5) @(negedge clk);
    pulse_en(0);
    n = 0;
    repeat (3000) begin @(negedge clk); if (rst_req) n++; end
    check("R9 no request while held", n, 0);
    pulse_en(1);
    wait_req(n);
    check("R9 remaining after resume", n, P0 * (MAXC + 1 - 100));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule